// File: doc/BRIEF.md
# Shifter Operand Unit with Carry-Out

This block forms the second operand of a 32-bit data-processing datapath, together with the carry bit that the shifter produces. It is purely combinational. It takes the operand field of the instruction, the value of the operand register, the low byte of the shift-amount register and the current carry flag. It returns the operand value and the shifter carry-out, which the flag logic picks up for logical operations.

There are three operand forms. The first is an 8-bit constant rotated right by an even amount. The second is a register shifted by a 5-bit constant taken from the instruction. The third is a register shifted by an amount held in another register.

A zero constant shift amount does not always mean "no shift". For a right shift it stands for a shift by 32. For a rotate it stands for a one-bit rotate through the carry flag. Register-specified amounts of zero, of exactly 32 and of more than 32 each follow their own carry rule.

The register file, the flag write-back and the ALU are outside this block.

Top module: `shifter_operand_unit`

## Requirements
- R1: With `imm_form_i`=1, `operand_o` is the zero-extended constant `op_field_i[7:0]` rotated right by twice the value of `op_field_i[11:8]`.
- R2: In the constant form, `carry_o` equals `carry_i` when `op_field_i[11:8]` is 0. Otherwise `carry_o` equals bit 31 of the rotated result.
- R3: With `imm_form_i`=0, the field layout is as follows:
  - `op_field_i[6:5]` picks the shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 rotate right.
  - `op_field_i[4]`=1 takes the amount from `rs_low_i`; `op_field_i[4]`=0 takes it from `op_field_i[11:7]`.
  - `op_field_i[3:0]` has no effect on the outputs.
  - In the register-amount case, `op_field_i[11:7]` has no effect. In the constant-amount case, `rs_low_i` has no effect.
- R4: A constant left shift with amount 0 passes `rm_val_i` through unchanged, and `carry_o` equals `carry_i`.
- R5: A constant shift of any kind with amount n in 1..31 gives the shifted or rotated value. `carry_o` is the last bit shifted out: bit 32-n of the input for a left shift, and bit n-1 for the other kinds.
- R6: A constant logical right shift with amount field 0 acts as a shift by 32. The result is 0 and `carry_o` is input bit 31.
- R7: A constant arithmetic right shift with amount field 0 acts as a shift by 32. Every result bit is input bit 31, and so is `carry_o`.
- R8: A constant rotate with amount field 0 rotates right by one through the carry. The result is the input shifted right by one with `carry_i` in bit 31, and `carry_o` is input bit 0.
- R9: A register-specified amount of 0 leaves `rm_val_i` unchanged, and `carry_o` equals `carry_i`.
- R10: A register-specified left or logical right shift by 1..31 behaves as in R5. A shift by exactly 32 gives 0, with `carry_o` equal to input bit 0 for a left shift and input bit 31 for a right shift.
- R11: A register-specified left or logical right shift by more than 32 gives 0 with `carry_o`=0.
- R12: A register-specified arithmetic right shift by 1..31 behaves as in R5. A shift by 32 or more fills every bit with input bit 31, and `carry_o` equals input bit 31.
- R13: A register-specified rotate uses the amount modulo 32. If the amount is nonzero but its low 5 bits are zero, the value is unchanged and `carry_o` is input bit 31. Otherwise `carry_o` is bit 31 of the rotated result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| imm_form_i | input | 1 | Selects the rotated-constant operand form |
| op_field_i | input | 12 | Operand field of the instruction |
| rm_val_i | input | 32 | Value of the operand register |
| rs_low_i | input | 8 | Low byte of the shift-amount register |
| carry_i | input | 1 | Current carry flag |
| operand_o | output | 32 | Second operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
The bench builds the block with its default 32-bit word, 8-bit register amount and 4-bit rotate field. With those values every input that controls the result can be swept in full:
- all 4096 constant/rotate pairs;
- all 32 constant amounts for each shift kind;
- all 256 register amounts for each shift kind.

Because the register amount is swept in full, the boundary amounts 0, 32, 33 and 64 fall inside the sweep, and so do the multiples of 32 that affect rotates. The data patterns are chosen so that bits 0 and 31 take both values, which makes every carry rule observable.

// File: rtl/sho_pkg.sv
package sho_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned SHAMT_W  = $clog2(WORD_W);
    localparam int unsigned RAMT_W   = 8;
    localparam int unsigned ROT_W    = 4;
    localparam int unsigned IMM_W    = 8;
    localparam int unsigned FIELD_W  = ROT_W + IMM_W;
    localparam int unsigned NW       = SHAMT_W + 1;
    localparam int unsigned REG_BIT  = 4;
    localparam int unsigned KIND_LSB = 5;
    localparam int unsigned AMT_LSB  = 7;

    typedef enum logic [1:0] {
        SK_LSL = 2'b00,
        SK_LSR = 2'b01,
        SK_ASR = 2'b10,
        SK_ROR = 2'b11
    } shift_kind_e;

    typedef struct packed {
        logic [WORD_W-1:0] value;
        logic              carry;
    } sh_res_t;

    typedef struct packed {
        logic [ROT_W-1:0] rot;
        logic [IMM_W-1:0] imm;
    } imm_dec_t;

    typedef struct packed {
        logic [SHAMT_W-1:0] amt;
        shift_kind_e        kind;
        logic               reg_amt;
        logic [3:0]         spare;
    } sh_dec_t;

    // Left shift by n in 1..WORD_W; carry is the last bit pushed out.
    function automatic sh_res_t shl_n(input logic [WORD_W-1:0] x,
                                      input logic [NW-1:0] n);
        logic [2*WORD_W-1:0] w;
        sh_res_t r;
        w       = {{WORD_W{1'b0}}, x} << n;
        r.value = w[WORD_W-1:0];
        r.carry = w[WORD_W];
        return r;
    endfunction

    // Logical right shift by n in 1..WORD_W.
    function automatic sh_res_t shr_n(input logic [WORD_W-1:0] x,
                                      input logic [NW-1:0] n);
        logic [2*WORD_W-1:0] w;
        sh_res_t r;
        w       = {x, {WORD_W{1'b0}}} >> n;
        r.value = w[2*WORD_W-1:WORD_W];
        r.carry = w[WORD_W-1];
        return r;
    endfunction

    // Arithmetic right shift by n in 1..WORD_W.
    function automatic sh_res_t sar_n(input logic [WORD_W-1:0] x,
                                      input logic [NW-1:0] n);
        logic signed [2*WORD_W-1:0] w;
        sh_res_t r;
        w       = {x, {WORD_W{1'b0}}};
        w       = w >>> n;
        r.value = w[2*WORD_W-1:WORD_W];
        r.carry = w[WORD_W-1];
        return r;
    endfunction

    // Rotate right by n in 1..WORD_W-1; carry is result MSB.
    function automatic sh_res_t ror_n(input logic [WORD_W-1:0] x,
                                      input logic [NW-1:0] n);
        logic [2*WORD_W-1:0] w;
        sh_res_t r;
        w       = {x, x} >> n;
        r.value = w[WORD_W-1:0];
        r.carry = w[WORD_W-1];
        return r;
    endfunction

endpackage

// File: rtl/sho_imm_rotate.sv
module sho_imm_rotate
    import sho_pkg::*;
(
    input  imm_dec_t dec_i,
    input  logic     carry_i,
    output sh_res_t  res_o
);
    logic [WORD_W-1:0] base;
    logic [NW-1:0]     n;

    assign base = {{(WORD_W-IMM_W){1'b0}}, dec_i.imm};
    assign n    = NW'({dec_i.rot, 1'b0});

    always_comb begin
        if (dec_i.rot == '0) begin
            res_o.value = base;
            res_o.carry = carry_i;
        end else begin
            res_o = ror_n(base, n);
        end
    end
endmodule

// File: rtl/sho_imm_shift.sv
module sho_imm_shift
    import sho_pkg::*;
(
    input  shift_kind_e        kind_i,
    input  logic [SHAMT_W-1:0] amt_i,
    input  logic [WORD_W-1:0]  x_i,
    input  logic               carry_i,
    output sh_res_t            res_o
);
    localparam logic [NW-1:0] FULL = NW'(WORD_W);

    logic          zero_amt;
    logic [NW-1:0] n;

    assign zero_amt = (amt_i == '0);
    assign n        = {1'b0, amt_i};

    always_comb begin
        res_o.value = x_i;
        res_o.carry = carry_i;
        unique case (kind_i)
            SK_LSL: if (!zero_amt) res_o = shl_n(x_i, n);
            SK_LSR: res_o = shr_n(x_i, zero_amt ? FULL : n);
            SK_ASR: res_o = sar_n(x_i, zero_amt ? FULL : n);
            SK_ROR: begin
                if (zero_amt) begin
                    res_o.value = {carry_i, x_i[WORD_W-1:1]};
                    res_o.carry = x_i[0];
                end else begin
                    res_o = ror_n(x_i, n);
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sho_reg_shift.sv
module sho_reg_shift
    import sho_pkg::*;
(
    input  shift_kind_e       kind_i,
    input  logic [RAMT_W-1:0] amt_i,
    input  logic [WORD_W-1:0] x_i,
    input  logic              carry_i,
    output sh_res_t           res_o
);
    localparam logic [NW-1:0] FULL = NW'(WORD_W);

    logic [SHAMT_W-1:0] low;
    logic               zero_amt;
    logic               past_full;
    logic               at_least_full;
    logic [NW-1:0]      clamped;

    assign low           = amt_i[SHAMT_W-1:0];
    assign zero_amt      = (amt_i == '0);
    assign past_full     = (amt_i > RAMT_W'(WORD_W));
    assign at_least_full = (amt_i >= RAMT_W'(WORD_W));
    assign clamped       = at_least_full ? FULL : {1'b0, low};

    always_comb begin
        res_o.value = x_i;
        res_o.carry = carry_i;
        if (!zero_amt) begin
            unique case (kind_i)
                SK_LSL: begin
                    if (past_full) res_o = '0;
                    else           res_o = shl_n(x_i, clamped);
                end
                SK_LSR: begin
                    if (past_full) res_o = '0;
                    else           res_o = shr_n(x_i, clamped);
                end
                SK_ASR: res_o = sar_n(x_i, clamped);
                SK_ROR: begin
                    if (low == '0) begin
                        res_o.value = x_i;
                        res_o.carry = x_i[WORD_W-1];
                    end else begin
                        res_o = ror_n(x_i, {1'b0, low});
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/shifter_operand_unit.sv
module shifter_operand_unit
    import sho_pkg::*;
(
    input  logic               imm_form_i,
    input  logic [FIELD_W-1:0] op_field_i,
    input  logic [WORD_W-1:0]  rm_val_i,
    input  logic [RAMT_W-1:0]  rs_low_i,
    input  logic               carry_i,
    output logic [WORD_W-1:0]  operand_o,
    output logic               carry_o
);
    imm_dec_t imm_dec;
    sh_dec_t  sh_dec;
    sh_res_t  rot_res;
    sh_res_t  ish_res;
    sh_res_t  rsh_res;
    sh_res_t  sel;

    assign imm_dec = imm_dec_t'(op_field_i);
    assign sh_dec  = sh_dec_t'(op_field_i);

    sho_imm_rotate u_rot (
        .dec_i   (imm_dec),
        .carry_i (carry_i),
        .res_o   (rot_res)
    );

    sho_imm_shift u_ish (
        .kind_i  (sh_dec.kind),
        .amt_i   (sh_dec.amt),
        .x_i     (rm_val_i),
        .carry_i (carry_i),
        .res_o   (ish_res)
    );

    sho_reg_shift u_rsh (
        .kind_i  (sh_dec.kind),
        .amt_i   (rs_low_i),
        .x_i     (rm_val_i),
        .carry_i (carry_i),
        .res_o   (rsh_res)
    );

    always_comb begin
        if (imm_form_i)          sel = rot_res;
        else if (sh_dec.reg_amt) sel = rsh_res;
        else                     sel = ish_res;
    end

    assign operand_o = sel.value;
    assign carry_o   = sel.carry;
endmodule

// File: rtl/sho_checker.sv
module sho_checker
    import sho_pkg::*;
(
    input logic               imm_form_i,
    input logic [FIELD_W-1:0] op_field_i,
    input logic [WORD_W-1:0]  rm_val_i,
    input logic [RAMT_W-1:0]  rs_low_i,
    input logic               carry_i,
    input logic [WORD_W-1:0]  operand_o,
    input logic               carry_o
);
    logic [1:0]         kind;
    logic               reg_sel;
    logic [SHAMT_W-1:0] iamt;
    logic               sign;

    assign kind    = op_field_i[KIND_LSB +: 2];
    assign reg_sel = op_field_i[REG_BIT];
    assign iamt    = op_field_i[AMT_LSB +: SHAMT_W];
    assign sign    = rm_val_i[WORD_W-1];

    always_comb begin
        if (imm_form_i && op_field_i[FIELD_W-1:IMM_W] == '0) begin
            // R2
            imm_rot0_chk: assert (operand_o == WORD_W'(op_field_i[IMM_W-1:0])
                                  && carry_o == carry_i);
        end
        if (!imm_form_i && !reg_sel && iamt == '0 && kind == 2'b00) begin
            // R4
            imm_lsl0_chk: assert (operand_o == rm_val_i && carry_o == carry_i);
        end
        if (!imm_form_i && !reg_sel && iamt == '0 && kind == 2'b01) begin
            // R6
            imm_lsr0_chk: assert (operand_o == '0 && carry_o == sign);
        end
        if (!imm_form_i && reg_sel && rs_low_i == '0) begin
            // R9
            reg_amt0_chk: assert (operand_o == rm_val_i && carry_o == carry_i);
        end
        if (!imm_form_i && reg_sel && !kind[1] && rs_low_i > RAMT_W'(WORD_W)) begin
            // R11
            reg_log_big_chk: assert (operand_o == '0 && carry_o == 1'b0);
        end
        if (!imm_form_i && reg_sel && kind == 2'b10 && rs_low_i >= RAMT_W'(WORD_W)) begin
            // R12
            reg_asr_big_chk: assert (operand_o == {WORD_W{sign}} && carry_o == sign);
        end
        if (!imm_form_i && reg_sel && kind == 2'b11 && rs_low_i != '0
            && rs_low_i[SHAMT_W-1:0] == '0) begin
            // R13
            reg_ror_wrap_chk: assert (operand_o == rm_val_i && carry_o == sign);
        end
    end
endmodule

bind shifter_operand_unit sho_checker u_chk (.*);

// File: tb/tb_shifter_operand_unit.sv
module tb_shifter_operand_unit;
    import sho_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               imm_form_i = 1'b0;
    logic [FIELD_W-1:0] op_field_i = '0;
    logic [WORD_W-1:0]  rm_val_i = '0;
    logic [RAMT_W-1:0]  rs_low_i = '0;
    logic               carry_i = 1'b0;
    logic [WORD_W-1:0]  operand_o;
    logic               carry_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    shifter_operand_unit dut (
        .imm_form_i (imm_form_i),
        .op_field_i (op_field_i),
        .rm_val_i   (rm_val_i),
        .rs_low_i   (rs_low_i),
        .carry_i    (carry_i),
        .operand_o  (operand_o),
        .carry_o    (carry_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 60000 && !done) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: cycles=%0d expected completion", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Bit-serial model written from the requirements.
    task automatic model(input logic im, input logic [11:0] f, input logic [31:0] x,
                         input logic [7:0] rs, input logic ci,
                         output logic [31:0] v, output logic c, output string tag);
        int n;
        logic [1:0] k;
        v = x; c = ci; n = 0; k = f[6:5];
        if (im) begin
            v = {24'b0, f[7:0]};
            n = 2 * int'(f[11:8]);
            k = 2'b11;
            tag = (f[11:8] == 0) ? "R2" : "R1";
        end else if (f[4]) begin
            n = int'(rs);
            if (n == 0)                 tag = "R9";
            else if (k == 2'b10)        tag = "R12";
            else if (k == 2'b11)        tag = "R13";
            else if (n <= 32)           tag = "R10";
            else                        tag = "R11";
        end else begin
            n = int'(f[11:7]);
            tag = "R5";
            if (n == 0) begin
                case (k)
                    2'b00: tag = "R4";
                    2'b01: begin tag = "R6"; n = 32; end
                    2'b10: begin tag = "R7"; n = 32; end
                    default: begin
                        tag = "R8";
                        c = x[0];
                        v = {ci, x[31:1]};
                        return;
                    end
                endcase
            end
        end
        for (int i = 0; i < n; i++) begin
            case (k)
                2'b00: begin c = v[31]; v = {v[30:0], 1'b0}; end
                2'b01: begin c = v[0];  v = {1'b0, v[31:1]}; end
                2'b10: begin c = v[0];  v = {v[31], v[31:1]}; end
                default: begin c = v[0]; v = {v[0], v[31:1]}; end
            endcase
        end
    endtask

    task automatic check(input logic im, input logic [11:0] f, input logic [31:0] x,
                         input logic [7:0] rs, input logic ci, input string force_tag);
        logic [31:0] ev;
        logic        ec;
        string       tag;
        @(negedge clk);
        imm_form_i = im; op_field_i = f; rm_val_i = x; rs_low_i = rs; carry_i = ci;
        #2;
        model(im, f, x, rs, ci, ev, ec, tag);
        if (force_tag != "") tag = force_tag;
        checks++;
        if (operand_o !== ev || carry_o !== ec) begin
            fails++;
            $display("FAIL %s: operand=%h carry=%b expected operand=%h carry=%b",
                     tag, operand_o, carry_o, ev, ec);
        end
    endtask

    logic [31:0] pats [6] = '{32'h8000_0001, 32'h7FFF_FFFE, 32'hA5C3_0F96,
                              32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678};

    initial begin
        repeat (3) @(posedge clk);
        // reset state: all-zero inputs, constant left shift by 0 (R4)
        check(1'b0, 12'h000, 32'h0, 8'h0, 1'b0, "R4");
        rst = 1'b0;

        // R1 R2: every rotate and constant, both carries
        for (int r = 0; r < 16; r++)
            for (int i = 0; i < 256; i++)
                for (int c = 0; c < 2; c++)
                    check(1'b1, {r[3:0], i[7:0]}, 32'hDEAD_BEEF, 8'h21, c[0], "");

        // R4..R8: constant shift amounts, all kinds
        for (int k = 0; k < 4; k++)
            for (int a = 0; a < 32; a++)
                for (int p = 0; p < 6; p++)
                    for (int c = 0; c < 2; c++)
                        check(1'b0, {a[4:0], k[1:0], 1'b0, 4'h0}, pats[p], 8'h40, c[0], "");

        // R9..R13: every register amount, all kinds
        for (int k = 0; k < 4; k++)
            for (int a = 0; a < 256; a++)
                for (int p = 0; p < 6; p++)
                    for (int c = 0; c < 2; c++)
                        check(1'b0, {5'd0, k[1:0], 1'b1, 4'h0}, pats[p], a[7:0], c[0], "");

        // R3: ignored field bits and ignored amount source
        for (int k = 0; k < 4; k++) begin
            check(1'b0, {5'd3, k[1:0], 1'b0, 4'hF}, 32'hA5C3_0F96, 8'd0,   1'b1, "R3");
            check(1'b0, {5'd3, k[1:0], 1'b0, 4'h5}, 32'hA5C3_0F96, 8'd200, 1'b0, "R3");
            check(1'b0, {5'd31, k[1:0], 1'b1, 4'hA}, 32'h8000_0001, 8'd5,  1'b1, "R3");
            check(1'b0, {5'd17, k[1:0], 1'b1, 4'h3}, 32'h8000_0001, 8'd33, 1'b0, "R3");
        end
        check(1'b1, 12'h3F1, 32'h1234_5678, 8'hFF, 1'b1, "R3");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule